// File: doc/BRIEF.md
# CAN Test-Mode Pin Routing Controller

This block sits between a CAN protocol core and the external transmit and receive pins. In normal operation it passes the core's serial output to the transmit pin and the receive pin to the core. When the chip-level test enable is set, a small test register selects how the signals are routed. Silent operation keeps the bus untouched while the core still sees its own dominant bits. Loop-back feeds the core's output straight back to its input. The two can be combined for a self-test that is invisible on the bus. A two-bit field overrides the transmit pin to show the sample-point strobe or a constant level.

The test register accepts writes only while the test enable is high. Dropping the enable returns every routing function to normal at once, and the stored fields clear on the next clock edge. The register also reports the receive pin and two trigger pins through a two-stage synchronizer. In loop-back the block asserts a mask output so the core does not flag acknowledge errors.

Top module: `can_test_route`

## Requirements
- R1: After reset all test fields read 0, the transmit pin follows the core transmit bit, the core receive input follows the receive pin, and the ack-error mask is 0.
- R2: A register write while the test enable is 0 has no effect: mode bits [3:0] stay 0 and routing stays normal.
- R3: Clearing the test enable restores normal routing in the same cycle, and mode bits [3:0] read 0 after the next clock edge.
- R4: Transmit-pin select field bits [1:0]: 0 = routed core output, 1 = sample-point strobe, 2 = constant dominant 0, 3 = constant recessive 1.
- R5: Silent bit [3] alone: the routed core output on the pin is recessive 1, and the core receive input is the AND of the receive pin and the core transmit bit.
- R6: Loop-back bit [2] alone: the core receive input equals the core transmit bit, the receive pin is ignored, and the routed core output on the pin is the core transmit bit.
- R7: The ack-error mask output is 1 exactly when loop-back is in effect (test enable 1 and bit [2] set).
- R8: Loop-back and silent both set: the core receive input equals the core transmit bit, the receive pin is ignored, and the routed core output on the pin is recessive 1.
- R9: Read-only bits [8] receive pin, [9] trigger A, [10] trigger B show the pin values two clock edges after they change. Writes do not alter them, and bits [7:4] and [15:11] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_en_i | input | 1 | Test enable from the control register |
| cfg_we_i | input | 1 | Test register write strobe |
| cfg_wdata_i | input | 4 | Write data for the writable fields [3:0] |
| cfg_rdata_o | output | 16 | Test register read value |
| core_tx_i | input | 1 | Serial transmit bit from the protocol core |
| core_sample_i | input | 1 | Sample-point strobe from the bit timing logic |
| pin_rx_i | input | 1 | External receive pin |
| trig_a_i | input | 1 | Trigger pin A (stop-watch) |
| trig_b_i | input | 1 | Trigger pin B (event) |
| core_rx_o | output | 1 | Receive input to the protocol core |
| pin_tx_o | output | 1 | External transmit pin |
| ack_err_mask_o | output | 1 | Suppresses acknowledge-error detection in the core |

## Verification
A wrong stored mode shows at once on the transmit pin and the core receive input, in the same cycle, for some combination of core bit and pin value. A lost write lock or a missed clear shows in bits [3:0] of the read value after one edge. A synchronizer with the wrong depth shifts the readback bits by one edge, so the readback is sampled exactly one and two edges after each pin change.

// File: rtl/can_test_pkg.sv
package can_test_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned CFG_W     = 4;
  localparam int unsigned SEL_LSB   = 0;
  localparam int unsigned LOOP_BIT  = 2;
  localparam int unsigned SIL_BIT   = 3;
  localparam int unsigned MON_LSB   = 8;
  localparam int unsigned MON_W     = 3;

  typedef enum logic [1:0] {
    TX_CORE   = 2'b00,
    TX_SAMPLE = 2'b01,
    TX_DOM    = 2'b10,
    TX_REC    = 2'b11
  } tx_sel_e;

  typedef struct packed {
    logic    silent;
    logic    loop;
    tx_sel_e sel;
  } mode_t;

  localparam mode_t MODE_NORMAL = '{silent: 1'b0, loop: 1'b0, sel: TX_CORE};
endpackage

// File: rtl/can_test_sync.sv
module can_test_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/can_test_regs.sv
module can_test_regs
  import can_test_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_en_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output mode_t            stored_o,
  output mode_t            eff_o
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d        = mode_q;
    mode_d.sel    = tx_sel_e'(wdata_i[SEL_LSB +: 2]);
    mode_d.loop   = wdata_i[LOOP_BIT];
    mode_d.silent = wdata_i[SIL_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_NORMAL;
    else if (!test_en_i) mode_q <= MODE_NORMAL;
    else if (we_i)      mode_q <= mode_d;
  end

  // enable gates the routing directly so a drop takes effect without a clock
  assign stored_o = mode_q;
  assign eff_o    = test_en_i ? mode_q : MODE_NORMAL;
endmodule

// File: rtl/can_test_mux.sv
module can_test_mux
  import can_test_pkg::*;
(
  input  mode_t mode_i,
  input  logic  core_tx_i,
  input  logic  core_sample_i,
  input  logic  pin_rx_i,
  output logic  core_rx_o,
  output logic  pin_tx_o,
  output logic  ack_err_mask_o
);
  logic tx_routed;

  always_comb begin
    if (mode_i.loop)        core_rx_o = core_tx_i;
    else if (mode_i.silent) core_rx_o = pin_rx_i & core_tx_i;
    else                    core_rx_o = pin_rx_i;
  end

  assign tx_routed = mode_i.silent ? 1'b1 : core_tx_i;

  always_comb begin
    unique case (mode_i.sel)
      TX_CORE:   pin_tx_o = tx_routed;
      TX_SAMPLE: pin_tx_o = core_sample_i;
      TX_DOM:    pin_tx_o = 1'b0;
      TX_REC:    pin_tx_o = 1'b1;
      default:   pin_tx_o = 1'b1;
    endcase
  end

  assign ack_err_mask_o = mode_i.loop;
endmodule

// File: rtl/can_test_route.sv
module can_test_route
  import can_test_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_en_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             core_tx_i,
  input  logic             core_sample_i,
  input  logic             pin_rx_i,
  input  logic             trig_a_i,
  input  logic             trig_b_i,
  output logic             core_rx_o,
  output logic             pin_tx_o,
  output logic             ack_err_mask_o
);
  mode_t            stored, eff;
  logic [MON_W-1:0] mon_sync;

  can_test_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .test_en_i(test_en_i),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .stored_o (stored),
    .eff_o    (eff)
  );

  can_test_sync #(.WIDTH(MON_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({trig_b_i, trig_a_i, pin_rx_i}),
    .q_o   (mon_sync)
  );

  can_test_mux u_mux (
    .mode_i        (eff),
    .core_tx_i     (core_tx_i),
    .core_sample_i (core_sample_i),
    .pin_rx_i      (pin_rx_i),
    .core_rx_o     (core_rx_o),
    .pin_tx_o      (pin_tx_o),
    .ack_err_mask_o(ack_err_mask_o)
  );

  always_comb begin
    cfg_rdata_o                      = '0;
    cfg_rdata_o[SEL_LSB +: 2]        = stored.sel;
    cfg_rdata_o[LOOP_BIT]            = stored.loop;
    cfg_rdata_o[SIL_BIT]             = stored.silent;
    cfg_rdata_o[MON_LSB +: MON_W]    = mon_sync;
  end
endmodule

// File: rtl/can_test_route_chk.sv
module can_test_route_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        test_en_i,
  input logic [15:0] cfg_rdata_o,
  input logic        core_tx_i,
  input logic        pin_rx_i,
  input logic        core_rx_o,
  input logic        pin_tx_o,
  input logic        ack_err_mask_o
);
  p_normal_route_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |-> (pin_tx_o == core_tx_i) && (core_rx_o == pin_rx_i));

  p_locked_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> cfg_rdata_o[3:0] == 4'h0);

  p_forced_dom_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && cfg_rdata_o[1:0] == 2'b10) |-> !pin_tx_o);

  p_silent_rec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && cfg_rdata_o[3] && cfg_rdata_o[1:0] == 2'b00) |-> pin_tx_o);

  p_loop_feed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && cfg_rdata_o[2]) |-> core_rx_o == core_tx_i);

  p_ack_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_mask_o == (test_en_i && cfg_rdata_o[2]));

  p_unused_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:4] == 4'h0 && cfg_rdata_o[15:11] == 5'h0);
endmodule

bind can_test_route can_test_route_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .test_en_i     (test_en_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .core_tx_i     (core_tx_i),
  .pin_rx_i      (pin_rx_i),
  .core_rx_o     (core_rx_o),
  .pin_tx_o      (pin_tx_o),
  .ack_err_mask_o(ack_err_mask_o)
);

// File: tb/can_test_route_tb_top.sv
module can_test_route_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        test_en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_wdata_i = 4'h0;
  logic [15:0] cfg_rdata_o;
  logic        core_tx_i = 1'b1, core_sample_i = 1'b0, pin_rx_i = 1'b1;
  logic        trig_a_i = 1'b0, trig_b_i = 1'b0;
  logic        core_rx_o, pin_tx_o, ack_err_mask_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  can_test_route dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // expected routing from the requirements
  task automatic model(input logic [1:0] sel, input logic lp, input logic sl, input logic en,
                       input logic tx, input logic smp, input logic rx,
                       output logic ptx, output logic crx, output logic msk);
    logic base;
    if (!en) begin sel = 2'b00; lp = 1'b0; sl = 1'b0; end
    crx  = lp ? tx : (sl ? (rx & tx) : rx);
    base = sl ? 1'b1 : tx;
    case (sel)
      2'b00: ptx = base;
      2'b01: ptx = smp;
      2'b10: ptx = 1'b0;
      default: ptx = 1'b1;
    endcase
    msk = en & lp;
  endtask

  task automatic sweep(input string req, input logic [3:0] m, input logic en);
    logic ptx, crx, msk;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk_i);
      core_tx_i = v[0]; core_sample_i = v[1]; pin_rx_i = v[2];
      #0.5;
      model(m[1:0], m[2], m[3], en, v[0], v[1], v[2], ptx, crx, msk);
      chk({req, " pin_tx"}, {15'h0, pin_tx_o}, {15'h0, ptx});
      chk({req, " core_rx"}, {15'h0, core_rx_o}, {15'h0, crx});
      chk("R7 ack mask", {15'h0, ack_err_mask_o}, {15'h0, msk});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", cfg_rdata_o, 16'h0000);
    sweep("R1", 4'h0, 1'b0);

    // R2 write locked while enable is low
    wr(4'hF);
    chk("R2 rdata", {12'h0, cfg_rdata_o[3:0]}, 16'h0);
    sweep("R2", 4'h0, 1'b0);

    // all mode combinations: R4 select, R5 silent, R6 loop, R8 both
    @(negedge clk_i); test_en_i = 1'b1;
    for (int m = 0; m < 16; m++) begin
      wr(m[3:0]);
      chk("R4 field readback", {12'h0, cfg_rdata_o[3:0]}, {12'h0, m[3:0]});
      if (m[3] && m[2])      sweep("R8", m[3:0], 1'b1);
      else if (m[3])         sweep("R5", m[3:0], 1'b1);
      else if (m[2])         sweep("R6", m[3:0], 1'b1);
      else                   sweep("R4", m[3:0], 1'b1);
    end

    // R3 enable drop restores normal routing at once
    wr(4'hE);
    @(negedge clk_i);
    test_en_i = 1'b0; core_tx_i = 1'b0; pin_rx_i = 1'b1;
    #0.5;
    chk("R3 pin_tx immediate", {15'h0, pin_tx_o}, 16'h0);
    chk("R3 core_rx immediate", {15'h0, core_rx_o}, 16'h1);
    chk("R3 mask immediate", {15'h0, ack_err_mask_o}, 16'h0);
    @(negedge clk_i);
    chk("R3 cleared", {12'h0, cfg_rdata_o[3:0]}, 16'h0);
    test_en_i = 1'b1;
    @(negedge clk_i);
    chk("R3 stays cleared", {12'h0, cfg_rdata_o[3:0]}, 16'h0);
    sweep("R3", 4'h0, 1'b1);

    // R9 readback latency and read-only bits
    pin_rx_i = 1'b0; trig_a_i = 1'b0; trig_b_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 idle", {13'h0, cfg_rdata_o[10:8]}, 16'h0);
    for (int p = 1; p < 8; p++) begin
      pin_rx_i = p[0]; trig_a_i = p[1]; trig_b_i = p[2];
      @(negedge clk_i);
      chk("R9 one edge", {13'h0, cfg_rdata_o[10:8]}, {13'h0, 3'(p - 1)});
      @(negedge clk_i);
      chk("R9 two edges", {13'h0, cfg_rdata_o[10:8]}, {13'h0, p[2:0]});
    end
    wr(4'hF);
    chk("R9 write keeps monitors", cfg_rdata_o, 16'h070F);
    wr(4'h0);
    chk("R9 unused zero", cfg_rdata_o, 16'h0700);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule